// File: doc/BRIEF.md
# Seeded random word peripheral

A register-mapped random number block on a simple 32-bit word bus. Software first fills five seed words. The block keeps a private record of which seed slots have received a write. Once all five have been written, software can select the generator and request a run with one control write. The engine is a 32-bit xorshift generator. It fills five output words over five clock cycles. During the run a busy flag is visible, and the previous output words stay readable. At the end a done flag is raised. Software can set or clear three of the done-style status flags, and only those three.

The bus accepts one access per cycle. Writes take effect on the clock edge where `busValid` and `busWrite` are high. Read data appears on `busRdata` in the cycle after the read strobe, and is zero when no read was issued. Only aligned full-word addresses decode.

Top module: `seeded_rng_regs`

## Requirements
- R1: After reset, control reads 0x00000000, status reads 0x00000001 (bit 0 ready), and all five output words read 0. Read data is returned one cycle after the read strobe.
- R2: Each write to a seed address (0x140 + 4·n, n = 0..4) marks slot n. Status bit 1 becomes 1 only once all five slots are marked, and repeated writes to the same slot do not count twice. Marks clear only on reset.
- R3: A control write (address 0x000) stores the written word with bit 4 forced to 0, so bit 4 always reads back 0.
- R4: A run starts only if three conditions hold in the written control word and the block: bit 3 is 1, bit 4 is 1, and status bit 1 is 1. The block must also be idle, so a trigger written during a run is dropped.
- R5: Status bit 2 (busy) is 1 for exactly five cycles after the triggering write edge. While busy, the output words (0x160 + 4·n) keep their previous values.
- R6: At the end of a run, status bit 5 is set. Output word k holds the (k+1)-th xorshift step of the engine state, where one step is x ^= x<<13; x ^= x>>17; x ^= x<<5.
- R7: The engine state is loaded only on the first run after reset. It is loaded with the XOR over n of seed n rotated left by n bits. Later runs continue from the last state and ignore newer seed writes.
- R8: A write to status (address 0x010) sets bits 5, 4 and 3 to the written values and leaves every other status bit unchanged. If a run finishes in the same cycle, bit 5 is set to 1.
- R9: Reads of any address other than control, status and the output words return 0, and this includes the seed addresses. Writes to any address other than control, status and the seed words have no effect, and this includes the output addresses.
- R10: If the seed mix is zero, the engine is loaded with 0x6D2B79F5 instead, so the state is never zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Access strobe, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 9 | Byte address inside the 0x200 window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, one cycle after the read strobe |

## Verification
The hardest situations to reach are those inside the five-cycle run: a read of an output word while the engine is busy, and a second trigger that lands before the run ends. The bench reaches both with back-to-back bus accesses issued right after the triggering write. It counts edges so that each read is captured in a known run cycle. It also sweeps every word address in the window for reads and for stray writes, and it repeats the run from reset with an all-zero seed set.

// File: rtl/srng_pkg.sv
package srng_pkg;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 9;
  localparam int NUM_WORDS = 5;
  localparam int IDX_W     = $clog2(NUM_WORDS);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = 9'h000;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 9'h010;
  localparam logic [ADDR_W-1:0] SEED_BASE = 9'h140;
  localparam logic [ADDR_W-1:0] OUT_BASE  = 9'h160;

  localparam int CTRL_SEL_BIT = 3;
  localparam int CTRL_GO_BIT  = 4;

  localparam int ST_READY  = 0;
  localparam int ST_SEEDED = 1;
  localparam int ST_BUSY   = 2;
  localparam int ST_PART   = 3;
  localparam int ST_MSG    = 4;
  localparam int ST_DONE   = 5;
  localparam int ST_ERR    = 7;

  localparam logic [DATA_W-1:0] ZERO_SEED_SUB = 32'h6D2B_79F5;
  localparam logic [DATA_W-1:0] GO_MASK = DATA_W'(1) << CTRL_GO_BIT;

  typedef struct packed {
    logic [NUM_WORDS-1:0] seedWr;
    logic                 loadSeed;
    logic                 step;
    logic                 commit;
    logic [IDX_W-1:0]     stepIdx;
  } engStrobe_t;

  function automatic logic [DATA_W-1:0] xorshiftStep(input logic [DATA_W-1:0] x);
    logic [DATA_W-1:0] t;
    t = x ^ (x << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  function automatic logic [DATA_W-1:0] rotl(input logic [DATA_W-1:0] x, input int sh);
    if (sh == 0) return x;
    return (x << sh) | (x >> (DATA_W - sh));
  endfunction
endpackage

// File: rtl/srng_ctrl.sv
module srng_ctrl
  import srng_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrlWord,
  output logic [DATA_W-1:0] statusWord,
  output engStrobe_t        strobe
);
  logic [DATA_W-1:0]    ctrlReg;
  logic [NUM_WORDS-1:0] seedMask;
  logic [NUM_WORDS-1:0] seedHit;
  logic                 busy;
  logic [IDX_W-1:0]     stepCnt;
  logic                 loaded;
  logic                 doneFlag;
  logic                 msgFlag;
  logic                 partFlag;
  logic                 ctrlWr;
  logic                 statWr;
  logic                 seedDone;
  logic                 goNow;
  logic                 lastStep;

  assign ctrlWr   = wrEn && (addr == CTRL_ADDR);
  assign statWr   = wrEn && (addr == STAT_ADDR);
  assign seedDone = &seedMask;
  assign goNow    = ctrlWr && wdata[CTRL_GO_BIT] && wdata[CTRL_SEL_BIT] && seedDone && !busy;
  assign lastStep = busy && (stepCnt == IDX_W'(NUM_WORDS - 1));

  for (genvar n = 0; n < NUM_WORDS; n++) begin : g_seedDec
    assign seedHit[n] = wrEn && (addr == SEED_BASE + ADDR_W'(4 * n));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      seedMask <= '0;
      busy     <= 1'b0;
      stepCnt  <= '0;
      loaded   <= 1'b0;
      doneFlag <= 1'b0;
      msgFlag  <= 1'b0;
      partFlag <= 1'b0;
    end else begin
      if (ctrlWr) ctrlReg <= wdata & ~GO_MASK;
      seedMask <= seedMask | seedHit;
      if (goNow) begin
        busy    <= 1'b1;
        stepCnt <= '0;
        loaded  <= 1'b1;
      end else if (busy) begin
        if (lastStep) busy <= 1'b0;
        else          stepCnt <= stepCnt + 1'b1;
      end
      if (statWr) begin
        partFlag <= wdata[ST_PART];
        msgFlag  <= wdata[ST_MSG];
        doneFlag <= wdata[ST_DONE];
      end
      if (lastStep) doneFlag <= 1'b1;
    end
  end

  always_comb begin
    statusWord            = '0;
    statusWord[ST_READY]  = 1'b1;
    statusWord[ST_SEEDED] = seedDone;
    statusWord[ST_BUSY]   = busy;
    statusWord[ST_PART]   = partFlag;
    statusWord[ST_MSG]    = msgFlag;
    statusWord[ST_DONE]   = doneFlag;
    statusWord[ST_ERR]    = 1'b0;
  end

  assign ctrlWord        = ctrlReg;
  assign strobe.seedWr   = seedHit;
  assign strobe.loadSeed = goNow && !loaded;
  assign strobe.step     = busy;
  assign strobe.commit   = lastStep;
  assign strobe.stepIdx  = stepCnt;

  // R2: slot marks never drop once set
  assert_mask_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((seedMask & $past(seedMask)) == $past(seedMask)));

  // R4: a run only begins after full seeding
  assert_seed_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(seedDone));

  // R5: the final step always ends the run
  assert_busy_ends_R5: assert property (@(posedge clk) disable iff (!rstN)
    lastStep |=> !busy);

  // R6: the done flag is up when busy drops
  assert_done_at_end_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> doneFlag);
endmodule

// File: rtl/srng_datapath.sv
module srng_datapath
  import srng_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  engStrobe_t        strobe,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] ctrlWord,
  input  logic [DATA_W-1:0] statusWord,
  output logic [DATA_W-1:0] rdata
);
  logic [NUM_WORDS-1:0][DATA_W-1:0] seedRegs;
  logic [NUM_WORDS-2:0][DATA_W-1:0] pendWords;
  logic [NUM_WORDS-1:0][DATA_W-1:0] outWords;
  logic [DATA_W-1:0]                engState;
  logic [DATA_W-1:0]                nextState;
  logic [DATA_W-1:0]                seedMix;
  logic [DATA_W-1:0]                readVal;

  assign nextState = xorshiftStep(engState);

  always_comb begin
    seedMix = '0;
    for (int n = 0; n < NUM_WORDS; n++) seedMix = seedMix ^ rotl(seedRegs[n], n);
  end

  for (genvar n = 0; n < NUM_WORDS; n++) begin : g_seedReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                seedRegs[n] <= '0;
      else if (strobe.seedWr[n]) seedRegs[n] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      engState  <= '0;
      pendWords <= '0;
      outWords  <= '0;
    end else begin
      if (strobe.loadSeed)  engState <= (seedMix == '0) ? ZERO_SEED_SUB : seedMix;
      else if (strobe.step) engState <= nextState;
      if (strobe.step && !strobe.commit) begin
        for (int k = 0; k < NUM_WORDS - 1; k++)
          if (strobe.stepIdx == IDX_W'(k)) pendWords[k] <= nextState;
      end
      if (strobe.commit) begin
        for (int k = 0; k < NUM_WORDS - 1; k++) outWords[k] <= pendWords[k];
        outWords[NUM_WORDS-1] <= nextState;
      end
    end
  end

  always_comb begin
    readVal = '0;
    if (addr == CTRL_ADDR) readVal = ctrlWord;
    if (addr == STAT_ADDR) readVal = statusWord;
    for (int n = 0; n < NUM_WORDS; n++)
      if (addr == OUT_BASE + ADDR_W'(4 * n)) readVal = outWords[n];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     rdata <= '0;
    else if (rdEn) rdata <= readVal;
    else           rdata <= '0;
  end

  // R10: the engine never steps from an all-zero state
  assert_state_nonzero_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |-> (engState != '0));

  // R5: visible output words hold while the run is in progress
  assert_out_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.commit) |=> $stable(outWords));

  // R6: commit only happens as part of a stepping cycle
  assert_commit_in_run_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |-> strobe.step);
endmodule

// File: rtl/seeded_rng_regs.sv
module seeded_rng_regs
  import srng_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata
);
  engStrobe_t        strobe;
  logic [DATA_W-1:0] ctrlWord;
  logic [DATA_W-1:0] statusWord;
  logic              wrEn;
  logic              rdEn;

  assign wrEn = busValid && busWrite;
  assign rdEn = busValid && !busWrite;

  srng_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .addr       (busAddr),
    .wdata      (busWdata),
    .ctrlWord   (ctrlWord),
    .statusWord (statusWord),
    .strobe     (strobe)
  );

  srng_datapath u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .rdEn       (rdEn),
    .addr       (busAddr),
    .wdata      (busWdata),
    .ctrlWord   (ctrlWord),
    .statusWord (statusWord),
    .rdata      (busRdata)
  );
endmodule

// File: tb/seeded_rng_regs_bench.sv
`timescale 1ns/1ps
module seeded_rng_regs_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [8:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;

  int compared = 0;
  int mismatched = 0;

  logic [31:0] mCtrl;
  logic [31:0] mStat;
  logic [31:0] mSeed [5];
  logic [31:0] mOut [5];
  logic [31:0] mState;
  bit          mLoaded;

  always #10 clk = ~clk;

  seeded_rng_regs u_seeded_rng_regs (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata)
  );

  function automatic logic [31:0] benchXs(input logic [31:0] v);
    logic [31:0] a;
    a = v ^ (v << 13);
    a = a ^ (a >> 17);
    return a ^ (a << 5);
  endfunction

  function automatic void modelRun();
    logic [31:0] mix;
    if (!mLoaded) begin
      mix = 32'h0;
      for (int n = 0; n < 5; n++)
        mix = mix ^ ((n == 0) ? mSeed[n] : ((mSeed[n] << n) | (mSeed[n] >> (32 - n))));
      mState = (mix == 32'h0) ? 32'h6D2B_79F5 : mix;
      mLoaded = 1'b1;
    end
    for (int k = 0; k < 5; k++) begin
      mState = benchXs(mState);
      mOut[k] = mState;
    end
  endfunction

  function automatic logic [31:0] expRead(input logic [8:0] a);
    if (a == 9'h000) return mCtrl;
    if (a == 9'h010) return mStat;
    for (int n = 0; n < 5; n++) if (a == 9'h160 + 9'(4 * n)) return mOut[n];
    return 32'h0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [8:0] a, input logic [31:0] d);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [8:0] a, output logic [31:0] d);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    @(negedge clk);
    busValid = 1'b0;
    d = busRdata;
  endtask

  task automatic checkRd(input string req, input logic [8:0] a, input logic [31:0] exp);
    logic [31:0] d;
    busRd(a, d);
    check(req, d, exp);
  endtask

  task automatic doReset();
    rstN = 1'b0; busValid = 1'b0; busWrite = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    mCtrl = 32'h0; mStat = 32'h1; mLoaded = 1'b0; mState = 32'h0;
    for (int n = 0; n < 5; n++) begin mOut[n] = 32'h0; mSeed[n] = 32'h0; end
  endtask

  task automatic sweepReads(input string req);
    for (int w = 0; w < 128; w++) checkRd(req, 9'(w * 4), expRead(9'(w * 4)));
  endtask

  task automatic checkOuts(input string req);
    for (int n = 0; n < 5; n++) checkRd(req, 9'h160 + 9'(4 * n), mOut[n]);
  endtask

  task automatic writeSeeds(input logic [31:0] base);
    for (int n = 0; n < 5; n++) begin
      mSeed[n] = base * (n + 3) + 32'h1357_9BDF * n;
      busWr(9'h140 + 9'(4 * n), mSeed[n]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] oldOut0;
    doReset();
    // R1: reset values and one-cycle read latency; R9: unmapped reads are zero
    sweepReads("R1/R9 reset sweep");

    // R4: trigger before seeding does nothing; R3: go bit reads back 0
    busWr(9'h000, 32'h18); mCtrl = 32'h08;
    checkRd("R4 no run unseeded", 9'h010, 32'h1);
    checkRd("R3 go bit cleared", 9'h000, 32'h08);

    // R2: four distinct slots plus a repeat is not enough
    for (int n = 0; n < 4; n++) begin
      mSeed[n] = 32'hA000_0001 + 32'h0101_0101 * n;
      busWr(9'h140 + 9'(4 * n), mSeed[n]);
    end
    busWr(9'h140, mSeed[0]);
    checkRd("R2 partial seeding", 9'h010, 32'h1);
    mSeed[4] = 32'h0BAD_F00D;
    busWr(9'h150, mSeed[4]);
    mStat = 32'h3;
    checkRd("R2 full seeding", 9'h010, 32'h3);

    // R4: each missing condition blocks a run
    busWr(9'h000, 32'h10); mCtrl = 32'h0;
    checkRd("R4 select missing", 9'h010, 32'h3);
    checkRd("R3 control readback", 9'h000, 32'h0);
    busWr(9'h000, 32'h08); mCtrl = 32'h08;
    checkRd("R4 start missing", 9'h010, 32'h3);

    // R5/R6: run timing, hold during busy, then results
    busWr(9'h000, 32'h18);
    oldOut0 = mOut[0];
    checkRd("R5 busy cycle 1", 9'h010, 32'h7);
    checkRd("R5 output held while busy", 9'h160, oldOut0);
    checkRd("R5 busy cycle 3", 9'h010, 32'h7);
    checkRd("R5 busy cycle 4", 9'h010, 32'h7);
    checkRd("R5 busy cycle 5", 9'h010, 32'h7);
    modelRun(); mStat = 32'h23;
    checkRd("R6 done after run", 9'h010, 32'h23);
    checkOuts("R6 output words");

    // R8: only bits 5,4,3 writable
    busWr(9'h010, 32'hFFFF_FFFF); mStat = 32'h3B;
    checkRd("R8 status write ones", 9'h010, 32'h3B);
    busWr(9'h010, 32'h0000_0010); mStat = 32'h13;
    checkRd("R8 status write mixed", 9'h010, 32'h13);
    busWr(9'h010, 32'h0); mStat = 32'h3;
    checkRd("R8 status write zero", 9'h010, 32'h3);

    // R7: new seeds are ignored, state continues
    writeSeeds(32'h2468_ACE1);
    busWr(9'h000, 32'h18);
    repeat (8) @(negedge clk);
    modelRun(); mStat = 32'h23;
    checkOuts("R7 continued sequence");
    checkRd("R6 done second run", 9'h010, 32'h23);
    busWr(9'h010, 32'h0); mStat = 32'h3;

    // R9: stray writes everywhere except control, status and seeds
    for (int w = 0; w < 128; w++) begin
      logic [8:0] a;
      a = 9'(w * 4);
      if (a != 9'h000 && a != 9'h010 && !(a >= 9'h140 && a <= 9'h150))
        busWr(a, 32'hFFFF_FFFF);
    end
    sweepReads("R9 after stray writes");

    // R4: a trigger during a run is dropped
    busWr(9'h000, 32'h18);
    busWr(9'h000, 32'h18);
    repeat (8) @(negedge clk);
    modelRun(); mStat = 32'h23;
    checkOuts("R4 retrigger dropped");

    // R3: all-ones control write stores with bit 4 clear and still runs
    busWr(9'h000, 32'hFFFF_FFFF); mCtrl = 32'hFFFF_FFEF;
    repeat (8) @(negedge clk);
    modelRun();
    checkRd("R3 all-ones control", 9'h000, 32'hFFFF_FFEF);
    checkOuts("R6 run from all-ones control");

    // R10: zero seed mix is replaced by the constant
    doReset();
    for (int n = 0; n < 5; n++) busWr(9'h140 + 9'(4 * n), 32'h0);
    mStat = 32'h3;
    busWr(9'h000, 32'h08); mCtrl = 32'h08;
    busWr(9'h000, 32'h18);
    repeat (8) @(negedge clk);
    modelRun(); mStat = 32'h23;
    checkOuts("R10 zero seed substitution");
    checkRd("R10 done flag", 9'h010, 32'h23);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule